// File: doc/BRIEF.md
# Draw Predication Control Unit

This block holds the state that decides whether a draw is executed or suppressed. Command strobes change that state: one turns predication on or off for the whole stream, one turns it on or off for the draws that follow, one loads a predicate bit directly, and one forms the predicate by testing a 64-bit operand against zero. The polarity of that zero test is chosen per command. Each draw request gets a run or skip answer in the same cycle.

Predication has two enable levels. Setting the stream-wide enable also clears any loaded predicate and turns the per-draw enable back on. The per-draw enable changes only itself. Internal draws can therefore bypass predication: clear the per-draw enable before the draw and set it again afterwards. A four-bit status word shows the whole state at all times.

Top module: `draw_pred_ctrl`

## Requirements
- R1: After a synchronous reset, `pred_stat` reads 4'b0010. Bit 0 is the global enable (0), bit 1 is the local enable (1), bit 2 is the predicate-loaded flag (0) and bit 3 is the predicate-fail bit (0, passing).
- R2: A global command with `glb_val`=1 sets the global enable and the local enable, clears the loaded flag and clears the fail bit. `pred_stat` reads 4'b0011 from the next cycle.
- R3: A global command with `glb_val`=0 clears only the global enable. Bits 3:1 of `pred_stat` keep their values.
- R4: A local command loads `loc_val` into bit 1 and leaves bits 0, 2 and 3 unchanged.
- R5: A latch command loads `lat_fail` into bit 3 and sets bit 2. Both bits then hold until the next latch, test or global-enable command.
- R6: A test command with `tst_mode`=0 treats an all-zero `tst_opnd` as passing and any other value as failing. The result goes to bit 3, and bit 2 is set.
- R7: A test command with `tst_mode`=1 treats a non-zero `tst_opnd` as passing and all-zero as failing.
- R8: `draw_skip` is 1 only when `draw_req` is 1 and bits 0, 1, 2 and 3 of the state are all 1. Any other draw request gives `draw_run`=1.
- R9: When several commands arrive in one cycle, only the highest-priority one acts. The order from highest is global, local, latch, test.
- R10: The draw answer is combinational from the state held before the clock edge. A command in the same cycle as a draw does not change that draw's answer.
- R11: With `draw_req`=0, both `draw_run` and `draw_skip` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_vld | input | 1 | Global enable command strobe |
| glb_val | input | 1 | New global enable value |
| loc_vld | input | 1 | Local enable command strobe |
| loc_val | input | 1 | New local enable value |
| lat_vld | input | 1 | Predicate latch strobe |
| lat_fail | input | 1 | Predicate to latch (1 = fail) |
| tst_vld | input | 1 | Zero-test command strobe |
| tst_mode | input | 1 | 0: zero passes; 1: non-zero passes |
| tst_opnd | input | 64 | Operand for the zero test, valid with the strobe |
| draw_req | input | 1 | Draw request |
| draw_run | output | 1 | Draw executes |
| draw_skip | output | 1 | Draw suppressed |
| pred_stat | output | 4 | {fail, loaded, local, global} |

## Verification
Two kinds of events can fall in the same cycle. The first is a draw request together with a command that changes state, such as a latch that makes the predicate fail while a draw is pending. The second is several command strobes together. The bench drives both on the same step. It judges the draw answer against the state from before the edge, and it judges the next `pred_stat` against a model that applies only the winning command in priority order.

// File: rtl/draw_pred_pkg.sv
package draw_pred_pkg;
  typedef struct packed {
    logic pred_fail;
    logic pred_set;
    logic loc_en;
    logic glb_en;
  } pred_state_t;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_GLB,
    CMD_LOC,
    CMD_LATCH,
    CMD_TEST
  } pred_cmd_e;

  localparam pred_state_t PRED_RESET = '{pred_fail: 1'b0, pred_set: 1'b0,
                                         loc_en: 1'b1, glb_en: 1'b0};
endpackage

// File: rtl/pred_zero_test.sv
module pred_zero_test #(
  parameter int OPND_W = 64
) (
  input  logic [OPND_W-1:0] opnd,
  input  logic              mode,
  output logic              fail
);
  logic is_zero;
  always_comb begin
    is_zero = (opnd == '0);
    // mode 0: zero passes; mode 1: non-zero passes
    fail = mode ? is_zero : !is_zero;
  end
endmodule

// File: rtl/pred_state_reg.sv
module pred_state_reg
  import draw_pred_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        glb_vld,
  input  logic        glb_val,
  input  logic        loc_vld,
  input  logic        loc_val,
  input  logic        lat_vld,
  input  logic        lat_fail,
  input  logic        tst_vld,
  input  logic        tst_fail,
  output pred_state_t state
);
  pred_cmd_e cmd;

  always_comb begin
    if (glb_vld)      cmd = CMD_GLB;
    else if (loc_vld) cmd = CMD_LOC;
    else if (lat_vld) cmd = CMD_LATCH;
    else if (tst_vld) cmd = CMD_TEST;
    else              cmd = CMD_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PRED_RESET;
    end else begin
      case (cmd)
        CMD_GLB: begin
          state.glb_en <= glb_val;
          if (glb_val) begin
            state.loc_en    <= 1'b1;
            state.pred_set  <= 1'b0;
            state.pred_fail <= 1'b0;
          end
        end
        CMD_LOC:   state.loc_en <= loc_val;
        CMD_LATCH: begin
          state.pred_set  <= 1'b1;
          state.pred_fail <= lat_fail;
        end
        CMD_TEST: begin
          state.pred_set  <= 1'b1;
          state.pred_fail <= tst_fail;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pred_decide.sv
module pred_decide
  import draw_pred_pkg::*;
(
  input  pred_state_t state,
  input  logic        draw_req,
  output logic        draw_run,
  output logic        draw_skip
);
  logic suppress;
  always_comb begin
    suppress  = state.glb_en & state.loc_en & state.pred_set & state.pred_fail;
    draw_skip = draw_req & suppress;
    draw_run  = draw_req & !suppress;
  end
endmodule

// File: rtl/draw_pred_ctrl.sv
module draw_pred_ctrl
  import draw_pred_pkg::*;
#(
  parameter int OPND_W = 64,
  localparam int STAT_W = $bits(pred_state_t)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_vld,
  input  logic              glb_val,
  input  logic              loc_vld,
  input  logic              loc_val,
  input  logic              lat_vld,
  input  logic              lat_fail,
  input  logic              tst_vld,
  input  logic              tst_mode,
  input  logic [OPND_W-1:0] tst_opnd,
  input  logic              draw_req,
  output logic              draw_run,
  output logic              draw_skip,
  output logic [STAT_W-1:0] pred_stat
);
  pred_state_t st;
  logic        tst_fail;

  pred_zero_test #(.OPND_W(OPND_W)) u_test (
    .opnd(tst_opnd), .mode(tst_mode), .fail(tst_fail)
  );

  pred_state_reg u_state (
    .clk(clk), .rst(rst),
    .glb_vld(glb_vld), .glb_val(glb_val),
    .loc_vld(loc_vld), .loc_val(loc_val),
    .lat_vld(lat_vld), .lat_fail(lat_fail),
    .tst_vld(tst_vld), .tst_fail(tst_fail),
    .state(st)
  );

  pred_decide u_decide (
    .state(st), .draw_req(draw_req),
    .draw_run(draw_run), .draw_skip(draw_skip)
  );

  assign pred_stat = st;
endmodule

// File: rtl/draw_pred_chk.sv
module draw_pred_chk #(
  parameter int OPND_W = 64,
  parameter int STAT_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_vld,
  input logic              glb_val,
  input logic              loc_vld,
  input logic              loc_val,
  input logic              lat_vld,
  input logic              lat_fail,
  input logic              tst_vld,
  input logic              tst_mode,
  input logic [OPND_W-1:0] tst_opnd,
  input logic              draw_req,
  input logic              draw_run,
  input logic              draw_skip,
  input logic [STAT_W-1:0] pred_stat
);
  assert_glb_on_R2: assert property (@(posedge clk) disable iff (rst)
    glb_vld && glb_val |=> pred_stat == 4'b0011);

  assert_glb_off_R3: assert property (@(posedge clk) disable iff (rst)
    glb_vld && !glb_val |=> !pred_stat[0] && pred_stat[3:1] == $past(pred_stat[3:1]));

  assert_local_only_R4: assert property (@(posedge clk) disable iff (rst)
    loc_vld && !glb_vld |=> pred_stat[1] == $past(loc_val) &&
      pred_stat[0] == $past(pred_stat[0]) && pred_stat[3:2] == $past(pred_stat[3:2]));

  assert_latch_R5: assert property (@(posedge clk) disable iff (rst)
    lat_vld && !glb_vld && !loc_vld |=> pred_stat[2] && pred_stat[3] == $past(lat_fail));

  assert_skip_cond_R8: assert property (@(posedge clk) disable iff (rst)
    draw_skip |-> pred_stat == 4'b1111 && draw_req);

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !draw_req |-> !draw_run && !draw_skip);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $countones({draw_run, draw_skip}) == {1'b0, draw_req});
endmodule

bind draw_pred_ctrl draw_pred_chk #(.OPND_W(OPND_W), .STAT_W(STAT_W)) u_chk (.*);

// File: tb/draw_pred_ctrl_bench.sv
module draw_pred_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_vld = 0, glb_val = 0, loc_vld = 0, loc_val = 0;
  logic lat_vld = 0, lat_fail = 0, tst_vld = 0, tst_mode = 0;
  logic [63:0] tst_opnd = '0;
  logic draw_req = 0;
  logic draw_run, draw_skip;
  logic [3:0] pred_stat;

  int checks = 0;
  int errors = 0;
  bit m_glb = 0, m_loc = 1, m_set = 0, m_fail = 0;

  always #5 clk = ~clk;

  draw_pred_ctrl u_draw_pred_ctrl (.*);

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive one cycle of stimulus at a negedge, check the same-cycle answer,
  // then advance the reference model across the edge and check the state.
  task automatic step(input bit gv, input bit gval, input bit lv, input bit lval,
                      input bit av, input bit aval, input bit tv, input bit tm,
                      input logic [63:0] op, input bit dr, input string req);
    bit sk;
    bit tf;
    @(negedge clk);
    glb_vld = gv; glb_val = gval; loc_vld = lv; loc_val = lval;
    lat_vld = av; lat_fail = aval; tst_vld = tv; tst_mode = tm;
    tst_opnd = op; draw_req = dr;
    #2;
    sk = dr && m_glb && m_loc && m_set && m_fail;
    chk({2'b00, draw_run, draw_skip}, {2'b00, dr && !sk, sk}, {req, " answer"});
    @(posedge clk);
    tf = tm ? (op == 0) : (op != 0);
    if (gv) begin
      m_glb = gval;
      if (gval) begin m_loc = 1; m_set = 0; m_fail = 0; end
    end else if (lv) m_loc = lval;
    else if (av) begin m_set = 1; m_fail = aval; end
    else if (tv) begin m_set = 1; m_fail = tf; end
    #1;
    chk(pred_stat, {m_fail, m_set, m_loc, m_glb}, {req, " state"});
  endtask

  task automatic idle(input bit dr, input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, '0, dr, req);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(pred_stat, 4'b0010, "R1 reset");
    idle(1, "R1 R8 default draw runs");
    step(1, 1, 0, 0, 0, 0, 0, 0, '0, 1, "R2 global on");
    step(0, 0, 0, 0, 1, 1, 0, 0, '0, 1, "R5 R10 latch fail with draw");
    idle(1, "R8 all set skips");
    idle(0, "R11 no request");
    idle(1, "R5 persists");
    step(0, 0, 1, 0, 0, 0, 0, 0, '0, 1, "R4 local off");
    idle(1, "R8 local off runs");
    step(0, 0, 1, 1, 0, 0, 0, 0, '0, 0, "R4 local on");
    idle(1, "R8 skip again");
    step(0, 0, 0, 0, 0, 0, 1, 0, 64'd0, 1, "R6 zero passes");
    idle(1, "R6 run");
    step(0, 0, 0, 0, 0, 0, 1, 0, 64'd5, 0, "R6 nonzero fails");
    idle(1, "R6 skip");
    step(0, 0, 0, 0, 0, 0, 1, 1, 64'h8000_0000_0000_0000, 0, "R7 nonzero passes");
    idle(1, "R7 run");
    step(0, 0, 0, 0, 0, 0, 1, 1, 64'd0, 1, "R7 zero fails");
    idle(1, "R7 skip");
    step(1, 0, 0, 0, 0, 0, 0, 0, '0, 1, "R3 global off");
    idle(1, "R3 R8 runs with global off");
    step(1, 1, 0, 0, 0, 0, 0, 0, '0, 0, "R2 global on clears");
    step(1, 1, 1, 0, 1, 1, 1, 0, 64'd3, 1, "R9 global wins");
    step(0, 0, 1, 0, 1, 1, 1, 0, 64'd3, 1, "R9 local beats latch");
    step(0, 0, 0, 0, 1, 0, 1, 0, 64'd3, 1, "R9 latch beats test");
    step(0, 0, 1, 1, 0, 0, 0, 0, '0, 1, "R4 restore local");
    step(0, 0, 0, 0, 1, 1, 0, 0, '0, 1, "R5 latch fail again");
    step(0, 0, 0, 0, 1, 0, 0, 0, '0, 1, "R10 old state answers");
    idle(1, "R10 new state answers");
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    chk(pred_stat, 4'b0010, "R1 reset again");
    m_glb = 0; m_loc = 1; m_set = 0; m_fail = 0;
    rst = 1'b0;
    idle(0, "R11 after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule